// File: doc/BRIEF.md
# Quad Supply Status Qualifier

This block turns four raw comparator results into qualified supply-health flags. Each comparator result is high while its monitored rail sits above its trip point. A channel reports good only after its input has stayed high, without a single break, for a long stability window. A channel that is already good stops reporting good only once its input has stayed low for longer than a short glitch window. Shorter dips are absorbed. The four qualified flags are combined into one power-good flag, which is high only when every channel is good.

Two gating inputs override everything. One is a monitoring enable. The other is a bias-valid signal that marks whether the supervisor's own supply is high enough to trust. When either gating input is low, every output is low in the same cycle and every channel forgets its progress, so qualification starts again from zero. The open-drain outputs of a board-level supervisor are modelled here as active-high logic levels. Both windows are parameters counted in clock cycles. A channel whose input is tied permanently high simply qualifies once and then stays good.

Comparator results are taken as synchronous to `clk`. Outputs are the registered channel states, masked by the gating inputs.

Top module: `supply_status_qualifier`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, every bit of `status_o` and `pgood_o` is 0.
- R2: With `en_i` and `bias_ok_i` both high, `status_o[i]` goes from 0 to 1 right after the clock edge at which `above_i[i]` has been sampled high on RISE_CYCLES consecutive edges, and not earlier.
- R3: A single low sample of `above_i[i]` while channel i is still qualifying restarts its count, so a further RISE_CYCLES consecutive high samples are needed.
- R4: With a channel good, `status_o[i]` drops to 0 right after the edge at which `above_i[i]` has been sampled low on FALL_CYCLES consecutive edges, and not earlier.
- R5: A low run on `above_i[i]` of fewer than FALL_CYCLES samples, followed by a high sample, leaves `status_o[i]` and `pgood_o` unchanged.
- R6: A channel failing or qualifying changes only its own bit of `status_o`.
- R7: `pgood_o` is 1 exactly when all bits of `status_o` are 1.
- R8: While `en_i` is 0, `status_o` and `pgood_o` are 0 in the same cycle. After `en_i` returns to 1, each channel needs a full RISE_CYCLES high run again.
- R9: While `bias_ok_i` is 0, `status_o` and `pgood_o` are 0 in the same cycle, and qualification restarts from zero when it returns to 1.
- R10: A channel whose `above_i` bit is held at 1 qualifies once and then never holds `pgood_o` low.
- R11: The cycle counters never wrap. An input held low for far longer than either window still needs exactly RISE_CYCLES high samples to qualify.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Monitoring enable; 0 forces all outputs low |
| bias_ok_i | input | 1 | Supervisor bias valid; 0 means lockout, all outputs low |
| above_i | input | NUM_CH | Per-channel comparator result, 1 = rail above threshold |
| status_o | output | NUM_CH | Per-channel qualified good flag |
| pgood_o | output | 1 | AND of all channel flags |

## Verification
The bench targets the exact edges of both windows. It checks a high run one sample short of the stability window and a low run one sample short of the glitch window. A design that is off by one here would report good too early, or would drop on a dip it should absorb. It breaks a stability count partway through: a design that paused instead of restarting would qualify about ten cycles early. It drops enable and bias in turn and checks the outputs in the same cycle. It checks that requalification afterwards takes the full window, which catches designs that register the gating or keep stale counts. It holds one channel low for hundreds of cycles before releasing it, so a wrapping counter would show up as an early or late rise.

// File: rtl/ssq_pkg.sv
package ssq_pkg;

    // Per-channel qualification state
    typedef enum logic {
        CH_QUAL = 1'b0,   // not yet good: counting consecutive high samples
        CH_GOOD = 1'b1    // good: counting consecutive low samples
    } ch_state_e;

    // Gating inputs bundled for the combine stage
    typedef struct packed {
        logic enable;
        logic bias_ok;
    } gate_t;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Bits needed to hold values 0..lim
    function automatic int unsigned cnt_width(input int unsigned lim);
        return (lim < 2) ? 1 : $clog2(lim + 1);
    endfunction

endpackage

// File: rtl/ssq_channel.sv
module ssq_channel
    import ssq_pkg::*;
#(
    parameter int unsigned RISE_CYCLES = 16,
    parameter int unsigned FALL_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic active_i,
    input  logic above_i,
    output logic good_o
);

    localparam int unsigned LIM = max_u(RISE_CYCLES, FALL_CYCLES);
    localparam int unsigned CW  = cnt_width(LIM);
    localparam logic [CW-1:0] RISE_LAST = CW'(RISE_CYCLES - 1);
    localparam logic [CW-1:0] FALL_LAST = CW'(FALL_CYCLES - 1);

    ch_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!active_i) begin
            state_d = CH_QUAL;
            cnt_d   = '0;
        end else begin
            case (state_q)
                CH_QUAL: begin
                    if (above_i) begin
                        if (cnt_q >= RISE_LAST) begin
                            state_d = CH_GOOD;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end else begin
                        cnt_d = '0;
                    end
                end
                CH_GOOD: begin
                    if (!above_i) begin
                        if (cnt_q >= FALL_LAST) begin
                            state_d = CH_QUAL;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end else begin
                        cnt_d = '0;
                    end
                end
                default: begin
                    state_d = CH_QUAL;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CH_QUAL;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign good_o = (state_q == CH_GOOD);

endmodule

// File: rtl/ssq_combine.sv
module ssq_combine
    import ssq_pkg::*;
#(
    parameter int unsigned NUM_CH = 4
) (
    input  gate_t             gate_i,
    input  logic [NUM_CH-1:0] good_i,
    output logic              active_o,
    output logic [NUM_CH-1:0] status_o,
    output logic              pgood_o
);

    assign active_o = gate_i.enable & gate_i.bias_ok;
    assign status_o = good_i & {NUM_CH{active_o}};
    assign pgood_o  = active_o & (&good_i);

endmodule

// File: rtl/supply_status_qualifier.sv
module supply_status_qualifier
    import ssq_pkg::*;
#(
    parameter int unsigned NUM_CH      = 4,
    parameter int unsigned RISE_CYCLES = 16_000_000,
    parameter int unsigned FALL_CYCLES = 3_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              bias_ok_i,
    input  logic [NUM_CH-1:0] above_i,
    output logic [NUM_CH-1:0] status_o,
    output logic              pgood_o
);

    gate_t             gate;
    logic              active;
    logic [NUM_CH-1:0] good;

    assign gate.enable  = en_i;
    assign gate.bias_ok = bias_ok_i;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        ssq_channel #(
            .RISE_CYCLES(RISE_CYCLES),
            .FALL_CYCLES(FALL_CYCLES)
        ) u_ch (
            .clk     (clk),
            .rst     (rst),
            .active_i(active),
            .above_i (above_i[i]),
            .good_o  (good[i])
        );
    end

    ssq_combine #(.NUM_CH(NUM_CH)) u_comb (
        .gate_i  (gate),
        .good_i  (good),
        .active_o(active),
        .status_o(status_o),
        .pgood_o (pgood_o)
    );

endmodule

// File: rtl/ssq_checker.sv
module ssq_checker #(
    parameter int unsigned NUM_CH      = 4,
    parameter int unsigned FALL_CYCLES = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              en_i,
    input logic              bias_ok_i,
    input logic [NUM_CH-1:0] above_i,
    input logic [NUM_CH-1:0] status_o,
    input logic              pgood_o
);

    localparam int unsigned RW = (FALL_CYCLES < 2) ? 1 : $clog2(FALL_CYCLES + 1);

    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (status_o == '0 && !pgood_o));

    a_r7_pgood_and: assert property (@(posedge clk) disable iff (rst)
        pgood_o == (&status_o));

    a_r8_enable_off: assert property (@(posedge clk) disable iff (rst)
        !en_i |-> (status_o == '0 && !pgood_o));

    a_r9_lockout: assert property (@(posedge clk) disable iff (rst)
        !bias_ok_i |-> (status_o == '0 && !pgood_o));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        logic [RW-1:0] low_run_q;

        always_ff @(posedge clk) begin
            if (rst || !(en_i && bias_ok_i) || above_i[i])
                low_run_q <= '0;
            else if (low_run_q < RW'(FALL_CYCLES))
                low_run_q <= low_run_q + 1'b1;
        end

        a_r2_rise_after_high: assert property (@(posedge clk) disable iff (rst)
            $rose(status_o[i]) |-> $past(above_i[i]));

        a_r4_fall_after_low: assert property (@(posedge clk) disable iff (rst)
            (en_i && bias_ok_i && $past(en_i && bias_ok_i) && $fell(status_o[i]))
            |-> !$past(above_i[i]));

        a_r5_glitch_hold: assert property (@(posedge clk) disable iff (rst)
            (en_i && bias_ok_i && $past(status_o[i]) && low_run_q < RW'(FALL_CYCLES))
            |-> status_o[i]);
    end

endmodule

bind supply_status_qualifier ssq_checker #(
    .NUM_CH     (NUM_CH),
    .FALL_CYCLES(FALL_CYCLES)
) u_chk (.*);

// File: tb/supply_status_qualifier_tb_top.sv
`timescale 1ns/1ps
module supply_status_qualifier_tb_top;

    localparam int NCH   = 4;
    localparam int R_CYC = 20;
    localparam int F_CYC = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           en_i = 1'b0;
    logic           bias_ok_i = 1'b0;
    logic [NCH-1:0] above_i = '0;
    logic [NCH-1:0] status_o;
    logic           pgood_o;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    supply_status_qualifier #(
        .NUM_CH     (NCH),
        .RISE_CYCLES(R_CYC),
        .FALL_CYCLES(F_CYC)
    ) dut_i (
        .clk      (clk),
        .rst      (rst),
        .en_i     (en_i),
        .bias_ok_i(bias_ok_i),
        .above_i  (above_i),
        .status_o (status_o),
        .pgood_o  (pgood_o)
    );

    // Behavioural reference: run lengths per channel, expected good flags
    int hi_run [NCH];
    int lo_run [NCH];
    bit m_good [NCH];

    initial for (int i = 0; i < NCH; i++) begin
        hi_run[i] = 0; lo_run[i] = 0; m_good[i] = 0;
    end

    always @(posedge clk) begin
        for (int i = 0; i < NCH; i++) begin
            if (rst || !(en_i && bias_ok_i)) begin
                hi_run[i] = 0; lo_run[i] = 0; m_good[i] = 0;
            end else if (!m_good[i]) begin
                lo_run[i] = 0;
                hi_run[i] = above_i[i] ? hi_run[i] + 1 : 0;
                if (hi_run[i] == R_CYC) begin m_good[i] = 1; hi_run[i] = 0; end
            end else begin
                hi_run[i] = 0;
                lo_run[i] = above_i[i] ? 0 : lo_run[i] + 1;
                if (lo_run[i] == F_CYC) begin m_good[i] = 0; lo_run[i] = 0; end
            end
        end
    end

    // Every-clock comparison against the reference
    always @(negedge clk) begin
        logic [NCH-1:0] exp_st;
        for (int i = 0; i < NCH; i++) exp_st[i] = m_good[i] & en_i & bias_ok_i;
        if (!done) begin
            total++;
            if (status_o !== exp_st || pgood_o !== (&exp_st)) begin
                fails++;
                $display("FAIL R2/R4/R7 model compare t=%0t: status=%b pgood=%b expected status=%b pgood=%b",
                         $time, status_o, pgood_o, exp_st, &exp_st);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #3;
    endtask

    task automatic chk(input string req, input logic [NCH-1:0] st_exp, input logic pg_exp);
        total++;
        if (status_o !== st_exp || pgood_o !== pg_exp) begin
            fails++;
            $display("FAIL %s: status=%b pgood=%b expected status=%b pgood=%b",
                     req, status_o, pgood_o, st_exp, pg_exp);
        end
    endtask

    initial begin
        tick(3);
        chk("R1 outputs low in reset", 4'b0000, 1'b0);
        rst = 1'b0; en_i = 1'b1; bias_ok_i = 1'b1; above_i = 4'b1111;
        #1 chk("R1 outputs low right after reset", 4'b0000, 1'b0);
        tick(R_CYC - 1);
        chk("R2 no rise one sample early", 4'b0000, 1'b0);
        tick(1);
        chk("R2 R7 R10 all channels qualify", 4'b1111, 1'b1);

        // R5: dip one shorter than glitch window
        above_i[1] = 1'b0;
        tick(F_CYC - 1);
        chk("R5 short dip held", 4'b1111, 1'b1);
        above_i[1] = 1'b1;
        tick(2);
        chk("R5 after short dip", 4'b1111, 1'b1);

        // R4 / R6: real failure on channel 2
        above_i[2] = 1'b0;
        tick(F_CYC - 1);
        chk("R4 no drop one sample early", 4'b1111, 1'b1);
        tick(1);
        chk("R4 R6 R7 channel 2 drops alone", 4'b1011, 1'b0);

        // R3: interrupted count restarts
        above_i[2] = 1'b1;
        tick(10);
        above_i[2] = 1'b0;
        tick(1);
        above_i[2] = 1'b1;
        tick(R_CYC - 1);
        chk("R3 restart needs full window", 4'b1011, 1'b0);
        tick(1);
        chk("R3 requalified after restart", 4'b1111, 1'b1);

        // R8: enable
        en_i = 1'b0;
        #1 chk("R8 enable low same cycle", 4'b0000, 1'b0);
        tick(5);
        chk("R8 enable low held", 4'b0000, 1'b0);
        en_i = 1'b1;
        tick(R_CYC - 1);
        chk("R8 requalify not early", 4'b0000, 1'b0);
        tick(1);
        chk("R8 requalify after full window", 4'b1111, 1'b1);

        // R9: bias lockout
        bias_ok_i = 1'b0;
        #1 chk("R9 lockout same cycle", 4'b0000, 1'b0);
        tick(3);
        bias_ok_i = 1'b1;
        tick(R_CYC - 1);
        chk("R9 requalify not early", 4'b0000, 1'b0);
        tick(1);
        chk("R9 requalify after lockout", 4'b1111, 1'b1);

        // R11 / R10: long low on channel 0, tied channel 3 unaffected
        above_i[0] = 1'b0;
        tick(F_CYC);
        chk("R10 R6 channel 0 fails, tied channel stays", 4'b1110, 1'b0);
        tick(200);
        chk("R11 long low", 4'b1110, 1'b0);
        above_i[0] = 1'b1;
        tick(R_CYC - 1);
        chk("R11 no early rise after long low", 4'b1110, 1'b0);
        tick(1);
        chk("R11 exact window after long low", 4'b1111, 1'b1);

        tick(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1'b1;
            total++;
            fails++;
            $display("FAIL watchdog expired: actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule